// File: doc/BRIEF.md
# Dual-Channel Half-Rate Output Splitter

This block is the digital back end of a two-channel sampler. Each channel presents one signed sample per clock. The sample is wider than the 8-bit output word, and a single strobe marks it valid for both channels. The block captures the samples on the falling clock edge. It clamps each sample to the 8-bit full-scale range and converts it to offset binary. It then splits each channel's stream across two output buses: a primary bus and a delayed bus. Each bus updates at half the sample rate.

Valid samples are numbered from reset, starting at zero. An even-numbered sample is the first of a pair and goes to the delayed bus. The odd-numbered sample that follows goes to the primary bus. The two words of a pair appear together, in the cycle marked by a one-cycle pair-valid pulse. A receiver restores the original order by reading the delayed word first and the primary word second. A single out-of-range flag covers both channels. It follows the same latency as the primary bus, so it lines up with the word pair it describes.

Cycle numbering: a sample is driven during clock cycle c and is taken at the falling edge inside that cycle. "Appears in cycle c+n" means the output is updated by the rising edge that opens cycle c+n.

Top module: `dual_demux`

## Requirements
- R1: While rst_ni is low, every data output is 0x00, and pair_vld_o and oor_o are 0.
- R2: An in-range sample v, with -128 <= v <= 127, is output as the 8-bit code v+128 (offset binary: the two's-complement byte with its MSB inverted).
- R3: A sample below -128 gives code 0x00, and a sample above 127 gives code 0xFF. The exact values -128 and 127 give 0x00 and 0xFF without counting as out of range.
- R4: When a pair is presented, oor_o is 1 if any of the four samples in it (two per channel) lies outside -128..127. Otherwise oor_o is 0.
- R5: Valid samples alternate: even-numbered ones go to the delayed bus and odd-numbered ones to the primary bus. pair_vld_o pulses for exactly one cycle per pair and is never high in two consecutive cycles.
- R6: An odd-numbered sample driven in cycle c appears on its channel's primary bus in cycle c+13. pair_vld_o is high in that same cycle.
- R7: The delayed bus carries the first sample of the pair, in the same cycle as its partner. When the two samples are driven in consecutive cycles, the first one appears 14 cycles after it was driven.
- R8: Between pair-valid pulses, all four buses and oor_o hold their values.
- R9: A cycle with smp_vld_i low is ignored. Its sample values never reach any output or the flag, and it does not advance the even/odd count.
- R10: Reading the delayed word and then the primary word, pulse after pulse, reproduces every channel's encoded sample sequence with no drop or duplicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; capture happens on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Marks both channel samples valid in this cycle |
| ch0_smp_i | input | IN_W | Channel 0 signed sample |
| ch1_smp_i | input | IN_W | Channel 1 signed sample |
| ch0_pri_o | output | 8 | Channel 0 primary bus (second sample of pair) |
| ch0_dly_o | output | 8 | Channel 0 delayed bus (first sample of pair) |
| ch1_pri_o | output | 8 | Channel 1 primary bus |
| ch1_dly_o | output | 8 | Channel 1 delayed bus |
| pair_vld_o | output | 1 | One-cycle pulse when a new pair is presented |
| oor_o | output | 1 | Out-of-range flag for the current pair, both channels combined |

## Verification
A slip in the delay line or the tag pipeline moves pair_vld_o off cycle c+13, and the per-cycle compare catches it at the first pair, within 14 cycles of the first valid sample. If the even/odd phase is flipped or advanced by an idle cycle, the two buses swap, which breaks the re-interleaved order at the next pulse. A stale hold register or a wrong flag combine shows up as a wrong delayed word or a wrong oor_o on the first pair whose first sample is out of range, or that follows a gap. The clamp boundaries are driven exactly at -129, -128, 127 and 128, so an off-by-one limit changes a code or the flag directly.

// File: rtl/dual_demux_pkg.sv
package dual_demux_pkg;
  localparam int CODE_W  = 8;
  localparam int PRI_LAT = 13;            // cycles, capture to primary bus
  localparam int LINE    = PRI_LAT - 2;   // regs between encoder and output stage

  typedef struct packed {
    logic vld;
    logic odd;
  } tag_t;

  typedef struct packed {
    logic              oor;
    logic [CODE_W-1:0] code;
  } enc_t;
endpackage

// File: rtl/smp_capture.sv
module smp_capture
  import dual_demux_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int NCH  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic [NCH-1:0][IN_W-1:0] smp_i,
  output tag_t                     tag_o,
  output logic [NCH-1:0][IN_W-1:0] smp_o
);
  logic phase_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      tag_o   <= '0;
      smp_o   <= '0;
    end else begin
      tag_o.vld <= vld_i;
      tag_o.odd <= phase_q;
      smp_o     <= smp_i;
      if (vld_i) phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/sat_encode.sv
module sat_encode
  import dual_demux_pkg::*;
#(
  parameter int IN_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [IN_W-1:0] smp_i,
  output enc_t                   enc_o
);
  localparam int POS_FS = 2 ** (CODE_W - 1) - 1;
  localparam int NEG_FS = -POS_FS - 1;

  enc_t enc_d;

  always_comb begin
    enc_d.oor = 1'b0;
    if (smp_i > POS_FS) begin
      enc_d.code = '1;
      enc_d.oor  = 1'b1;
    end else if (smp_i < NEG_FS) begin
      enc_d.code = '0;
      enc_d.oor  = 1'b1;
    end else begin
      enc_d.code = {~smp_i[CODE_W-1], smp_i[CODE_W-2:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) enc_o <= '0;
    else         enc_o <= enc_d;
  end

  // R3
  clamp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_o.oor |-> (enc_o.code == '0 || enc_o.code == '1));
endmodule

// File: rtl/pair_demux.sv
module pair_demux
  import dual_demux_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  tag_t                       tag_i,
  input  enc_t [NCH-1:0]             enc_i,
  output logic [NCH-1:0][CODE_W-1:0] pri_o,
  output logic [NCH-1:0][CODE_W-1:0] dly_o,
  output logic                       vld_o,
  output logic                       oor_o
);
  tag_t           tag_q [LINE+1];
  enc_t [NCH-1:0] dat_q [LINE];
  enc_t [NCH-1:0] hold_q;
  tag_t           tap_tag;
  enc_t [NCH-1:0] tap_dat;
  logic           pair_oor;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s <= LINE; s++) tag_q[s] <= '0;
      for (int s = 0; s < LINE; s++)  dat_q[s] <= '0;
    end else begin
      tag_q[0] <= tag_i;
      dat_q[0] <= enc_i;
      for (int s = 1; s <= LINE; s++) tag_q[s] <= tag_q[s-1];
      for (int s = 1; s < LINE; s++)  dat_q[s] <= dat_q[s-1];
    end
  end

  assign tap_tag = tag_q[LINE];
  assign tap_dat = dat_q[LINE-1];

  always_comb begin
    pair_oor = 1'b0;
    for (int c = 0; c < NCH; c++) pair_oor |= tap_dat[c].oor | hold_q[c].oor;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pri_o  <= '0;
      dly_o  <= '0;
      vld_o  <= 1'b0;
      oor_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (tap_tag.vld) begin
        if (tap_tag.odd) begin
          for (int c = 0; c < NCH; c++) begin
            pri_o[c] <= tap_dat[c].code;
            dly_o[c] <= hold_q[c].code;
          end
          oor_o <= pair_oor;
          vld_o <= 1'b1;
        end else begin
          hold_q <= tap_dat;   // first of pair waits for its partner
        end
      end
    end
  end

  // R5
  pulse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

  // R6
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(tag_i.vld && tag_i.odd, PRI_LAT));

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> ($stable(pri_o) && $stable(dly_o) && $stable(oor_o)));
endmodule

// File: rtl/dual_demux.sv
module dual_demux
  import dual_demux_pkg::*;
#(
  parameter int IN_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   smp_vld_i,
  input  logic signed [IN_W-1:0] ch0_smp_i,
  input  logic signed [IN_W-1:0] ch1_smp_i,
  output logic [CODE_W-1:0]      ch0_pri_o,
  output logic [CODE_W-1:0]      ch0_dly_o,
  output logic [CODE_W-1:0]      ch1_pri_o,
  output logic [CODE_W-1:0]      ch1_dly_o,
  output logic                   pair_vld_o,
  output logic                   oor_o
);
  localparam int NCH = 2;

  logic [NCH-1:0][IN_W-1:0]   smp_in, smp_cap;
  tag_t                       tag_cap;
  enc_t [NCH-1:0]             enc;
  logic [NCH-1:0][CODE_W-1:0] pri, dly;

  assign smp_in = {ch1_smp_i, ch0_smp_i};

  smp_capture #(.IN_W(IN_W), .NCH(NCH)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (smp_vld_i),
    .smp_i  (smp_in),
    .tag_o  (tag_cap),
    .smp_o  (smp_cap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sat_encode #(.IN_W(IN_W)) u_enc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp_cap[c]),
      .enc_o  (enc[c])
    );
  end

  pair_demux #(.NCH(NCH)) u_dmx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (tag_cap),
    .enc_i  (enc),
    .pri_o  (pri),
    .dly_o  (dly),
    .vld_o  (pair_vld_o),
    .oor_o  (oor_o)
  );

  assign ch0_pri_o = pri[0];
  assign ch0_dly_o = dly[0];
  assign ch1_pri_o = pri[1];
  assign ch1_dly_o = dly[1];

  // R4
  oor_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_o |-> (ch0_pri_o inside {8'h00, 8'hFF} || ch0_dly_o inside {8'h00, 8'hFF} ||
               ch1_pri_o inside {8'h00, 8'hFF} || ch1_dly_o inside {8'h00, 8'hFF}));
endmodule

// File: tb/sim_dual_demux.sv
module sim_dual_demux;
  localparam int IN_W = 12;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_vld_i = 1'b0;
  logic signed [IN_W-1:0] ch0_smp_i = '0, ch1_smp_i = '0;
  logic [7:0] ch0_pri_o, ch0_dly_o, ch1_pri_o, ch1_dly_o;
  logic pair_vld_o, oor_o;

  always #2 clk = ~clk;   // 250 MHz

  dual_demux #(.IN_W(IN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i),
    .ch0_smp_i(ch0_smp_i), .ch1_smp_i(ch1_smp_i),
    .ch0_pri_o(ch0_pri_o), .ch0_dly_o(ch0_dly_o),
    .ch1_pri_o(ch1_pri_o), .ch1_dly_o(ch1_dly_o),
    .pair_vld_o(pair_vld_o), .oor_o(oor_o)
  );

  int nvec = 0, nerr = 0;
  int cyc = 0, nsmp = 0, nrec = 0;
  bit hv [HMAX];
  int hk [HMAX];
  int sa [HMAX], sb [HMAX];
  int ra [HMAX], rb [HMAX];
  int e_pa = 0, e_da = 0, e_pb = 0, e_db = 0, e_or = 0;

  function automatic int enc(input int v);
    if (v > 127)  return 255;
    if (v < -128) return 0;
    return v + 128;
  endfunction

  function automatic int rng(input int v);
    return (v > 127 || v < -128) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_cycle();
    bit ev = 1'b0;
    if (cyc >= 13 && hv[cyc-13] && hk[cyc-13][0]) begin
      int k = hk[cyc-13];
      e_pa = enc(sa[k]);   e_da = enc(sa[k-1]);
      e_pb = enc(sb[k]);   e_db = enc(sb[k-1]);
      e_or = rng(sa[k]) | rng(sa[k-1]) | rng(sb[k]) | rng(sb[k-1]);
      ev = 1'b1;
    end
    chk(pair_vld_o == ev, "R5", int'(pair_vld_o), int'(ev));
    chk(int'(ch0_pri_o) == e_pa, ev ? "R6" : "R8", int'(ch0_pri_o), e_pa);
    chk(int'(ch1_pri_o) == e_pb, ev ? "R6" : "R8", int'(ch1_pri_o), e_pb);
    chk(int'(ch0_dly_o) == e_da, ev ? "R7" : "R8", int'(ch0_dly_o), e_da);
    chk(int'(ch1_dly_o) == e_db, ev ? "R7" : "R8", int'(ch1_dly_o), e_db);
    chk(int'(oor_o) == e_or, ev ? "R4" : "R8", int'(oor_o), e_or);
    if (pair_vld_o && nrec + 1 < HMAX) begin
      ra[nrec] = int'(ch0_dly_o); rb[nrec] = int'(ch1_dly_o); nrec++;
      ra[nrec] = int'(ch0_pri_o); rb[nrec] = int'(ch1_pri_o); nrec++;
    end
  endtask

  task automatic step(input int a, input int b, input bit v);
    @(posedge clk); #1;
    ch0_smp_i = a[IN_W-1:0];
    ch1_smp_i = b[IN_W-1:0];
    smp_vld_i = v;
    hv[cyc] = v;
    if (v) begin
      sa[nsmp] = a; sb[nsmp] = b; hk[cyc] = nsmp; nsmp++;
    end
    #2;
    check_cycle();
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2047, -2048, 1'b0);
  endtask

  task automatic pair_flush(input int a0, input int a1, input int b0, input int b1);
    step(a0, b0, 1'b1);
    step(a1, b1, 1'b1);
    idle(13);
  endtask

  task automatic t_reset();
    ch0_smp_i = 12'sd300; smp_vld_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: all outputs cleared while reset is low
    chk(ch0_pri_o == 8'h00 && ch1_pri_o == 8'h00, "R1", int'(ch0_pri_o), 0);
    chk(ch0_dly_o == 8'h00 && ch1_dly_o == 8'h00, "R1", int'(ch0_dly_o), 0);
    chk(!pair_vld_o && !oor_o, "R1", int'({pair_vld_o, oor_o}), 0);
    smp_vld_i = 1'b0; ch0_smp_i = '0;
    rst_ni = 1'b1;
  endtask

  task automatic t_ramp();
    for (int k = 0; k < 20; k++) step(k * 11 - 100, 50 - k * 6, 1'b1);
    idle(13);
    // R2: last pair offset binary (a: 98, 109; b: -58, -64)
    chk(ch0_pri_o == 8'd237, "R2", int'(ch0_pri_o), 237);
    chk(ch0_dly_o == 8'd226, "R2", int'(ch0_dly_o), 226);
    chk(ch1_pri_o == 8'd64,  "R2", int'(ch1_pri_o), 64);
    chk(ch1_dly_o == 8'd70,  "R2", int'(ch1_dly_o), 70);
  endtask

  task automatic t_saturate();
    pair_flush(-128, 127, 0, -1);
    // R3: exact full-scale values, no flag
    chk(ch0_dly_o == 8'h00 && ch0_pri_o == 8'hFF, "R3", int'({ch0_dly_o, ch0_pri_o}), 16'h00FF);
    chk(oor_o == 1'b0, "R3", int'(oor_o), 0);
    pair_flush(-129, 128, 10, 10);
    // R3: one step beyond full scale clamps and flags
    chk(ch0_dly_o == 8'h00 && ch0_pri_o == 8'hFF, "R3", int'({ch0_dly_o, ch0_pri_o}), 16'h00FF);
    chk(oor_o == 1'b1, "R4", int'(oor_o), 1);
    pair_flush(-2048, 2047, 0, 0);
    chk(ch0_dly_o == 8'h00 && ch0_pri_o == 8'hFF, "R3", int'({ch0_dly_o, ch0_pri_o}), 16'h00FF);
    pair_flush(5, 6, -300, 7);
    // R4: channel 1 first sample alone raises the shared flag
    chk(oor_o == 1'b1 && ch1_dly_o == 8'h00, "R4", int'({oor_o, ch1_dly_o}), 9'h100);
    pair_flush(1, 2, 3, 4);
    chk(oor_o == 1'b0, "R4", int'(oor_o), 0);
  endtask

  task automatic t_gaps();
    step(20, -20, 1'b1);
    idle(3);
    step(21, -21, 1'b1);
    idle(1);
    step(22, -22, 1'b1);
    step(23, -23, 1'b1);
    idle(2);
    step(24, -24, 1'b1);
    step(25, -25, 1'b1);
    idle(14);
    // R9: junk on idle cycles never reached outputs or flag
    chk(ch0_dly_o == 8'd152 && ch0_pri_o == 8'd153, "R9", int'({ch0_dly_o, ch0_pri_o}), 16'h9899);
    chk(oor_o == 1'b0, "R9", int'(oor_o), 0);
    chk(ch1_dly_o == 8'd104 && ch1_pri_o == 8'd103, "R9", int'({ch1_dly_o, ch1_pri_o}), 16'h6867);
  endtask

  task automatic t_interleave();
    int bad = 0;
    // R10: dly-then-pri stream equals input order, nothing dropped or doubled
    chk(nrec == nsmp, "R10", nrec, nsmp);
    for (int i = 0; i < nrec && i < nsmp; i++) begin
      if (ra[i] != enc(sa[i]) || rb[i] != enc(sb[i])) bad++;
    end
    chk(bad == 0, "R10", bad, 0);
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_saturate();
    t_gaps();
    t_interleave();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nvec++; nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule